// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block holds the power control state of a small 8-bit microcontroller core and turns it into the signals that slow or stop the rest of the chip. A four-bit control register, written over a one-cycle write strobe, carries an idle request, a power-down request and two general-purpose flags. From that register the block produces a freeze for the CPU clock, a stop for the oscillator and all clocks, and the override controls for the external bus pins.

Idle and power-down are left in different ways. Any enabled interrupt ends idle by clearing the idle bit, and a filtered hardware reset also ends it. Power-down ignores interrupts and is left only by reset. The reset input passes through a filter that recognises a reset only after it has been held for a set number of consecutive oscillator cycles. The pin overrides depend on both the active mode and whether code is being fetched from external memory.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: With both mode bits clear, a write stores the data in the register on the next edge. Bit 0 is the idle request, bit 1 is power-down, and bits 2 and 3 are the flags. The register is always readable on `pcon_o`.
- R2: With only the idle bit set, `cpu_hold_o` is 1 and `clk_stop_o` is 0. Both outputs change on the edge that stores the write.
- R3: With the power-down bit set, `clk_stop_o` and `cpu_hold_o` are both 1.
- R4: A write that sets bits 0 and 1 together stores power-down only, and bit 0 reads back as 0.
- R5: When idle is active and `irq_i` is 1, the next edge clears the idle bit and leaves both flags unchanged.
- R6: `irq_i` has no effect while power-down is active.
- R7: Writes are ignored while either mode bit is set.
- R8: `rst_done_o` rises on the edge that completes 24 consecutive cycles with `ext_rst_i` high. It stays high while the input is held. While it is high, the next edge clears all four register bits.
- R9: A reset pulse shorter than 24 cycles leaves `rst_done_o` at 0 and the register unchanged.
- R10: In idle, `strobe_hold_o` is 1 and `strobe_level_o` is 1. In power-down, `strobe_hold_o` is 1 and `strobe_level_o` is 0. In normal operation both are 0.
- R11: `p0_float_o` is 1 only when a mode is active and `ext_fetch_i` is 1.
- R12: `p2_addr_o` is 1 when `ext_fetch_i` is 1 and power-down is not active.
- R13: If a write that sets idle arrives in the same cycle as `irq_i`, the write takes effect and idle is entered. The interrupt ends only an idle that is already in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous power-on initialisation, active low |
| ext_rst_i | input | 1 | Raw hardware reset request, active high |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 4 | Register write data |
| irq_i | input | 1 | An enabled interrupt is pending |
| ext_fetch_i | input | 1 | Code is fetched from external memory |
| pcon_o | output | 4 | Control register contents |
| cpu_hold_o | output | 1 | CPU clock freeze |
| clk_stop_o | output | 1 | Oscillator and global clock stop |
| rst_done_o | output | 1 | Filtered reset recognised |
| strobe_hold_o | output | 1 | Override the address-latch and program-store strobes |
| strobe_level_o | output | 1 | Level for the overridden strobes |
| p0_float_o | output | 1 | Port 0 is released to high impedance |
| p2_addr_o | output | 1 | Port 2 drives the address rather than port data |

## Verification
Two pairs of events can fall in the same cycle: a write and an interrupt, and a completed reset and an interrupt or write. The bench drives these together on purpose, once in directed steps and many times under random stimulus. In every cycle it compares the register and all pin outputs against a model built from the priority order of R8, R7, R13 and R5.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int REG_W = 4;

    typedef struct packed {
        logic flag1;
        logic flag0;
        logic pd;
        logic idle;
    } pcon_t;
endpackage

// File: rtl/pmc_rst_filter.sv
module pmc_rst_filter #(
    parameter int HOLD = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_rst_i,
    output logic done_o
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!ext_rst_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != LIMIT) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.done = (st_d.cnt == LIMIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o = st_q.done;

    // R8: done is only reported while the request was present on the edge before
    p_done_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(ext_rst_i));
    // R9: a released request drops done on the next edge
    p_release_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rst_i |=> !done_o);
endmodule

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
    import pmc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr_i,
    input  logic  wr_en_i,
    input  pcon_t wr_data_i,
    input  logic  irq_i,
    output pcon_t pcon_o
);
    typedef struct packed {
        pcon_t pcon;
    } st_t;

    st_t  st_d, st_q;
    logic busy;

    assign busy = st_q.pcon.idle | st_q.pcon.pd;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.pcon = '0;
        end else if (wr_en_i && !busy) begin
            st_d.pcon      = wr_data_i;
            st_d.pcon.idle = wr_data_i.idle & ~wr_data_i.pd;
        end else if (irq_i && st_q.pcon.idle && !st_q.pcon.pd) begin
            st_d.pcon.idle = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pcon_o = st_q.pcon;

    // R6: power-down persists until the filtered reset
    p_pd_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pcon_o.pd && !clr_i) |=> pcon_o.pd);
    // R5: an interrupt ends idle and keeps the flags
    p_irq_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pcon_o.idle && irq_i && !clr_i) |=> (!pcon_o.idle && $stable(pcon_o.flag0) && $stable(pcon_o.flag1)));
    // R7: the flags are frozen while a mode is active
    p_wr_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pcon_o.idle || pcon_o.pd) && !clr_i) |=> ($stable(pcon_o.flag0) && $stable(pcon_o.flag1)));
    // R8: a recognised reset empties the register
    p_reset_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (pcon_o == '0));
    // R4: the two mode bits are never set together
    p_single_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(pcon_o.idle && pcon_o.pd));
endmodule

// File: rtl/pmc_pin_steer.sv
module pmc_pin_steer (
    input  logic idle_i,
    input  logic pd_i,
    input  logic ext_fetch_i,
    output logic strobe_hold_o,
    output logic strobe_level_o,
    output logic p0_float_o,
    output logic p2_addr_o
);
    logic any_mode;

    always_comb begin
        any_mode       = idle_i | pd_i;
        strobe_hold_o  = any_mode;
        strobe_level_o = idle_i & ~pd_i;
        p0_float_o     = any_mode & ext_fetch_i;
        p2_addr_o      = ext_fetch_i & ~pd_i;
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int RST_HOLD = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_rst_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             irq_i,
    input  logic             ext_fetch_i,
    output logic [REG_W-1:0] pcon_o,
    output logic             cpu_hold_o,
    output logic             clk_stop_o,
    output logic             rst_done_o,
    output logic             strobe_hold_o,
    output logic             strobe_level_o,
    output logic             p0_float_o,
    output logic             p2_addr_o
);
    pcon_t pcon_q;
    logic  done;

    pmc_rst_filter #(.HOLD(RST_HOLD)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_rst_i (ext_rst_i),
        .done_o    (done)
    );

    pmc_ctrl_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (done),
        .wr_en_i   (wr_en_i),
        .wr_data_i (pcon_t'(wr_data_i)),
        .irq_i     (irq_i),
        .pcon_o    (pcon_q)
    );

    pmc_pin_steer u_pins (
        .idle_i         (pcon_q.idle),
        .pd_i           (pcon_q.pd),
        .ext_fetch_i    (ext_fetch_i),
        .strobe_hold_o  (strobe_hold_o),
        .strobe_level_o (strobe_level_o),
        .p0_float_o     (p0_float_o),
        .p2_addr_o      (p2_addr_o)
    );

    assign pcon_o     = pcon_q;
    assign cpu_hold_o = pcon_q.idle | pcon_q.pd;
    assign clk_stop_o = pcon_q.pd;
    assign rst_done_o = done;

    // R3: a stopped clock always implies a held CPU
    p_stop_holds_cpu_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stop_o |-> (cpu_hold_o && strobe_hold_o && !strobe_level_o));
endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_rst = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = '0;
    logic       irq = 1'b0;
    logic       ext_fetch = 1'b0;
    logic [3:0] pcon;
    logic       cpu_hold, clk_stop, rst_done, s_hold, s_lvl, p0f, p2a;

    int checks = 0;
    int errors = 0;

    logic [3:0] m_pcon = '0;
    int         m_cnt  = 0;
    logic       m_done = 1'b0;

    always #2 clk = ~clk;

    pwr_mode_ctrl u_pwr_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_rst_i(ext_rst), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .irq_i(irq), .ext_fetch_i(ext_fetch),
        .pcon_o(pcon), .cpu_hold_o(cpu_hold), .clk_stop_o(clk_stop),
        .rst_done_o(rst_done), .strobe_hold_o(s_hold), .strobe_level_o(s_lvl),
        .p0_float_o(p0f), .p2_addr_o(p2a)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] next_pcon(logic [3:0] cur, logic done, logic w,
                                             logic [3:0] d, logic i);
        logic [3:0] n = cur;
        if (done)                          n = 4'b0000;
        else if (w && cur[1:0] == 2'b00)   n = {d[3:2], d[1], d[0] & ~d[1]};
        else if (i && cur[0] && !cur[1])   n[0] = 1'b0;
        return n;
    endfunction

    task automatic check_all();
        logic idle_m = m_pcon[0];
        logic pd_m   = m_pcon[1];
        chk("R1 pcon", pcon, m_pcon);
        chk("R2 cpu_hold", cpu_hold, idle_m | pd_m);
        chk("R3 clk_stop", clk_stop, pd_m);
        chk("R8 rst_done", rst_done, m_done);
        chk("R10 strobe_hold", s_hold, idle_m | pd_m);
        chk("R10 strobe_level", s_lvl, idle_m & ~pd_m);
        chk("R11 p0_float", p0f, (idle_m | pd_m) & ext_fetch);
        chk("R12 p2_addr", p2a, ext_fetch & ~pd_m);
    endtask

    // called at a falling edge; drives, crosses one rising edge, checks
    task automatic step(input logic r, input logic w, input logic [3:0] d,
                        input logic i, input logic f);
        ext_rst = r; wr_en = w; wr_data = d; irq = i; ext_fetch = f;
        @(posedge clk);
        m_pcon = next_pcon(m_pcon, m_done, w, d, i);
        if (r) m_cnt = (m_cnt < 24) ? m_cnt + 1 : 24;
        else   m_cnt = 0;
        m_done = (m_cnt == 24);
        @(negedge clk);
        check_all();
    endtask

    task automatic hold_reset(input int n);
        for (int k = 0; k < n; k++) step(1'b1, 1'b0, 4'h0, 1'b0, 1'b0);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7331));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all();                                        // reset state, R1
        // R1 plain write of flags, R12 with external fetch in normal mode
        step(0, 1, 4'b1100, 0, 1);
        step(0, 1, 4'b0100, 0, 1);
        // R2 idle entry, R11 port 0 floats
        step(0, 1, 4'b1001, 0, 1);
        // R7 write ignored in idle
        step(0, 1, 4'b0010, 0, 1);
        chk("R7 write ignored in idle", pcon, 4'b1001);
        // R5 interrupt wakes, flags kept
        step(0, 0, 4'h0, 1, 0);
        chk("R5 wake keeps flag", pcon, 4'b1000);
        // R13 write and interrupt together: write wins
        step(0, 1, 4'b0101, 1, 0);
        chk("R13 idle entered", pcon[0], 1);
        step(0, 0, 4'h0, 1, 0);
        // R4 both bits: power-down only
        step(0, 1, 4'b0011, 0, 1);
        chk("R4 pd only", pcon, 4'b0010);
        // R6 interrupt ignored in power-down
        step(0, 0, 4'h0, 1, 1);
        chk("R6 pd kept", clk_stop, 1);
        // R9 short pulse ignored
        hold_reset(23);
        step(0, 0, 4'h0, 0, 1);
        chk("R9 short pulse", pcon, 4'b0010);
        // R8 full pulse with an interrupt in the clearing cycle
        hold_reset(24);
        chk("R8 done raised", rst_done, 1);
        step(1, 1, 4'b1111, 1, 0);
        chk("R8 cleared", pcon, 4'b0000);
        step(0, 0, 4'h0, 0, 0);

        // random phase
        begin
            int burst = 0;
            for (int n = 0; n < 3000; n++) begin
                logic [3:0] d;
                logic r;
                d = 4'($urandom);
                d[1] = ($urandom % 6 == 0);
                if (burst == 0 && $urandom % 60 == 0) burst = 18 + int'($urandom % 12);
                r = (burst > 0);
                if (burst > 0) burst--;
                step(r, 1'($urandom % 3 == 0), d, 1'($urandom % 4 == 0), 1'($urandom));
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule